// File: doc/BRIEF.md
# Dual-Channel Converter Data-Ready Controller

This block drives the data-ready signal of a two-channel sigma-delta converter. Each channel's filter produces a sample-valid strobe. The block turns those strobes into a one-cycle, active-low pulse on a shared data-ready pin. The pin can either idle released, so several devices can share it with a pull-up, or idle actively driven high. A two-bit mode chooses how the channels map onto the pin. In the linked mode, the pin follows only the lagging channel, and both channel words are snapshotted together at that single event. The three independent modes route channel 0, channel 1, or either channel to the pin.

An optional settling hold suppresses events until three converter-period ticks have passed since a channel left reset or shutdown. After that point, events flow every period. The channel words presented for reading are copied from the snapshots when a read begins, so an event that lands during a read cannot disturb the words being shifted out. Two status flags, one per channel, are set by a status read and cleared by that channel's data-ready event. The modulators, filters, phase logic and serial port are outside the block and appear only as strobes and data inputs.

Top module: `adc_ready_ctrl`

## Requirements
- R1: After reset, dr_pin is 1, dr_oe is 0, stat_flags is 2'b11, and both rd_data words are 0.
- R2: When no pulse is active, dr_oe equals the cfg_idle_drive value of the previous cycle (1 = idle driven high, 0 = idle released), and dr_pin is 1.
- R3: A qualified event produces dr_pin = 0 with dr_oe = 1 for exactly the one cycle after the strobe is sampled. A cycle with no strobe yields no pulse in the next cycle.
- R4: Mode encodings are 2'b01 (channel 0 events only), 2'b10 (channel 1 events only) and 2'b11 (events of either channel).
- R5: In mode 2'b00, only the lagging channel's strobe can pulse the pin (lag_sel 0 means channel 0 lags, 1 means channel 1 lags). That event also requires the other channel to be active and settled.
- R6: In mode 2'b00, no pulse is produced while either chan_off bit is set.
- R7: In the independent modes, a channel whose chan_off bit is set generates no events, while the other channel's events still appear.
- R8: With cfg_settle_en = 1, a channel's strobes are ignored until three period_tick cycles have been sampled after its chan_off was last seen high. A strobe is ignored in the same cycle as the third tick.
- R9: With cfg_settle_en = 0, strobes from an active channel qualify immediately after it leaves reset or shutdown.
- R10: In mode 2'b00, the linked event snapshots both channel words. In the other modes, each channel's own qualified event snapshots only its word, whether or not that channel is routed to the pin.
- R11: rd_start copies the snapshots, as they stood before that edge, to rd_data0/rd_data1. Without rd_start, the read words do not change.
- R12: stat_rd sets both stat_flags bits to 1. A qualified event of a channel clears its bit, and the clear wins over a simultaneous stat_rd. In mode 2'b00, the linked event clears both bits together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_settle_en | input | 1 | Hold off events for three periods after channel start |
| cfg_idle_drive | input | 1 | 1: pin idles driven high; 0: pin idles released |
| cfg_mode | input | 2 | Pin routing mode (00 linked, 01 ch0, 10 ch1, 11 either) |
| lag_sel | input | 1 | Lagging channel index used in linked mode |
| chan_off | input | 2 | Per-channel reset/shutdown flag |
| period_tick | input | 1 | One-cycle tick per converter output period |
| smp_valid | input | 2 | Per-channel filter sample-valid strobe |
| chan_data0 | input | DW | Channel 0 filter word |
| chan_data1 | input | DW | Channel 1 filter word |
| rd_start | input | 1 | Start-of-read pulse |
| stat_rd | input | 1 | Status register read pulse |
| dr_pin | output | 1 | Data-ready pin value (active low) |
| dr_oe | output | 1 | Data-ready pin output enable |
| rd_data0 | output | DW | Channel 0 word presented for reading |
| rd_data1 | output | DW | Channel 1 word presented for reading |
| stat_flags | output | 2 | Per-channel data-ready status flags |

## Verification
Several properties are checked on every cycle:
- a released pin is never low;
- idle drive follows its configuration bit;
- a strobe-free cycle or a disabled channel never produces a pulse;
- read words only move on rd_start;
- status bits only rise after a status read.

Some behaviours need the bench's scenarios instead. These are the settling count after shutdown, the choice of the lagging channel in linked mode, the capture of both words at the linked event versus each word at its own event, and the clear-over-set priority of the status flags. The bench exercises them under directed sequences and long random runs against its own cycle model.

// File: rtl/adc_ready_pkg.sv
package adc_ready_pkg;

    typedef enum logic [1:0] {
        MODE_LINKED = 2'b00,
        MODE_CH0    = 2'b01,
        MODE_CH1    = 2'b10,
        MODE_ANY    = 2'b11
    } dr_mode_e;

    localparam int unsigned NUM_CH        = 2;
    localparam int unsigned SETTLE_TICKS  = 3;

endpackage

// File: rtl/adc_settle_gate.sv
module adc_settle_gate #(
    parameter int unsigned HOLD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic off,
    input  logic tick,
    output logic done
);
    localparam int unsigned CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (off) begin
            st_d.cnt = '0;
        end else if (tick && (st_q.cnt != LIMIT)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done = (st_q.cnt == LIMIT);

endmodule

// File: rtl/adc_ready_router.sv
module adc_ready_router
    import adc_ready_pkg::*;
(
    input  logic              settle_en,
    input  logic [1:0]        mode,
    input  logic              lag_sel,
    input  logic [NUM_CH-1:0] chan_off,
    input  logic [NUM_CH-1:0] smp_valid,
    input  logic [NUM_CH-1:0] settled,
    output logic              pulse,
    output logic [NUM_CH-1:0] snap_ld,
    output logic [NUM_CH-1:0] stat_clr
);
    logic [NUM_CH-1:0] ch_ok;
    logic [NUM_CH-1:0] ch_ev;
    logic              linked_ev;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_qual
        assign ch_ok[g] = !chan_off[g] && (!settle_en || settled[g]);
        assign ch_ev[g] = smp_valid[g] && ch_ok[g];
    end

    assign linked_ev = ch_ev[lag_sel] && ch_ok[!lag_sel];

    always_comb begin
        pulse    = 1'b0;
        snap_ld  = ch_ev;
        stat_clr = ch_ev;
        unique case (dr_mode_e'(mode))
            MODE_LINKED: begin
                pulse    = linked_ev;
                snap_ld  = {NUM_CH{linked_ev}};
                stat_clr = {NUM_CH{linked_ev}};
            end
            MODE_CH0: pulse = ch_ev[0];
            MODE_CH1: pulse = ch_ev[1];
            MODE_ANY: pulse = |ch_ev;
            default:  pulse = 1'b0;
        endcase
    end

endmodule

// File: rtl/adc_ready_capture.sv
module adc_ready_capture
    import adc_ready_pkg::*;
#(
    parameter int unsigned DW = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH-1:0]          snap_ld,
    input  logic                       rd_start,
    input  logic [NUM_CH-1:0][DW-1:0]  live,
    output logic [NUM_CH-1:0][DW-1:0]  rd_word
);
    typedef struct packed {
        logic [NUM_CH-1:0][DW-1:0] snap;
        logic [NUM_CH-1:0][DW-1:0] rd;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (snap_ld[i]) begin
                st_d.snap[i] = live[i];
            end
        end
        if (rd_start) begin
            st_d.rd = st_q.snap;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_word = st_q.rd;

endmodule

// File: rtl/adc_ready_ctrl.sv
module adc_ready_ctrl
    import adc_ready_pkg::*;
#(
    parameter int unsigned DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_settle_en,
    input  logic          cfg_idle_drive,
    input  logic [1:0]    cfg_mode,
    input  logic          lag_sel,
    input  logic [1:0]    chan_off,
    input  logic          period_tick,
    input  logic [1:0]    smp_valid,
    input  logic [DW-1:0] chan_data0,
    input  logic [DW-1:0] chan_data1,
    input  logic          rd_start,
    input  logic          stat_rd,
    output logic          dr_pin,
    output logic          dr_oe,
    output logic [DW-1:0] rd_data0,
    output logic [DW-1:0] rd_data1,
    output logic [1:0]    stat_flags
);
    logic [NUM_CH-1:0]         settled;
    logic                      pulse;
    logic [NUM_CH-1:0]         snap_ld;
    logic [NUM_CH-1:0]         stat_clr;
    logic [NUM_CH-1:0][DW-1:0] live;
    logic [NUM_CH-1:0][DW-1:0] rd_word;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_settle
        adc_settle_gate #(.HOLD(SETTLE_TICKS)) u_gate (
            .clk   (clk),
            .rst_n (rst_n),
            .off   (chan_off[g]),
            .tick  (period_tick),
            .done  (settled[g])
        );
    end

    adc_ready_router u_router (
        .settle_en (cfg_settle_en),
        .mode      (cfg_mode),
        .lag_sel   (lag_sel),
        .chan_off  (chan_off),
        .smp_valid (smp_valid),
        .settled   (settled),
        .pulse     (pulse),
        .snap_ld   (snap_ld),
        .stat_clr  (stat_clr)
    );

    assign live[0] = chan_data0;
    assign live[1] = chan_data1;

    adc_ready_capture #(.DW(DW)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .snap_ld  (snap_ld),
        .rd_start (rd_start),
        .live     (live),
        .rd_word  (rd_word)
    );

    typedef struct packed {
        logic              pin;
        logic              oe;
        logic [NUM_CH-1:0] stat;
    } pin_st_t;

    pin_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pin = !pulse;
        st_d.oe  = cfg_idle_drive || pulse;
        if (stat_rd) begin
            st_d.stat = '1;
        end
        st_d.stat = st_d.stat & ~stat_clr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pin  <= 1'b1;
            st_q.oe   <= 1'b0;
            st_q.stat <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dr_pin     = st_q.pin;
    assign dr_oe      = st_q.oe;
    assign stat_flags = st_q.stat;
    assign rd_data0   = rd_word[0];
    assign rd_data1   = rd_word[1];

endmodule

// File: rtl/adc_ready_ctrl_chk.sv
module adc_ready_ctrl_chk #(
    parameter int unsigned DW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_idle_drive,
    input logic [1:0]    cfg_mode,
    input logic [1:0]    chan_off,
    input logic [1:0]    smp_valid,
    input logic          rd_start,
    input logic          stat_rd,
    input logic          dr_pin,
    input logic          dr_oe,
    input logic [DW-1:0] rd_data0,
    input logic [DW-1:0] rd_data1,
    input logic [1:0]    stat_flags
);
    p_released_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dr_oe |-> dr_pin);

    p_idle_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_idle_drive |=> dr_oe);

    p_no_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid == 2'b00) |=> dr_pin);

    p_linked_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b00 && chan_off != 2'b00) |=> dr_pin);

    p_ch0_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b01 && chan_off[0]) |=> dr_pin);

    p_read_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_start |=> ($stable(rd_data0) && $stable(rd_data1)));

    p_stat_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> (!$rose(stat_flags[0]) && !$rose(stat_flags[1])));

endmodule

bind adc_ready_ctrl adc_ready_ctrl_chk #(.DW(DW)) u_chk (.*);

// File: tb/adc_ready_ctrl_tb.sv
module adc_ready_ctrl_tb;
    localparam int unsigned DW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_settle_en = 1'b0;
    logic          cfg_idle_drive = 1'b0;
    logic [1:0]    cfg_mode = 2'b01;
    logic          lag_sel = 1'b0;
    logic [1:0]    chan_off = 2'b00;
    logic          period_tick = 1'b0;
    logic [1:0]    smp_valid = 2'b00;
    logic [DW-1:0] chan_data0 = '0;
    logic [DW-1:0] chan_data1 = '0;
    logic          rd_start = 1'b0;
    logic          stat_rd = 1'b0;
    logic          dr_pin, dr_oe;
    logic [DW-1:0] rd_data0, rd_data1;
    logic [1:0]    stat_flags;

    int n_vec = 0;
    int n_bad = 0;

    // model state
    int unsigned   m_cnt [2];
    logic [1:0]    m_stat;
    logic [DW-1:0] m_snap [2];
    logic [DW-1:0] m_rd [2];
    logic          m_pin, m_oe;

    always #2.5 clk = ~clk;

    adc_ready_ctrl #(.DW(DW)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_cnt[i] = 0; m_snap[i] = '0; m_rd[i] = '0;
        end
        m_stat = 2'b11; m_pin = 1'b1; m_oe = 1'b0;
    endtask

    task automatic model_step();
        logic [1:0] ok, ev;
        logic linked, pulse;
        logic [1:0] ld;
        for (int i = 0; i < 2; i++) begin
            ok[i] = !chan_off[i] && (!cfg_settle_en || m_cnt[i] == 3);
            ev[i] = smp_valid[i] && ok[i];
        end
        linked = ev[lag_sel] && ok[!lag_sel];
        case (cfg_mode)
            2'b00: begin pulse = linked; ld = {2{linked}}; end
            2'b01: begin pulse = ev[0]; ld = ev; end
            2'b10: begin pulse = ev[1]; ld = ev; end
            default: begin pulse = |ev; ld = ev; end
        endcase
        if (rd_start) begin m_rd[0] = m_snap[0]; m_rd[1] = m_snap[1]; end
        if (ld[0]) m_snap[0] = chan_data0;
        if (ld[1]) m_snap[1] = chan_data1;
        if (stat_rd) m_stat = 2'b11;
        m_stat = m_stat & ~ld;
        for (int i = 0; i < 2; i++) begin
            if (chan_off[i]) m_cnt[i] = 0;
            else if (period_tick && m_cnt[i] < 3) m_cnt[i]++;
        end
        m_pin = !pulse;
        m_oe  = cfg_idle_drive || pulse;
    endtask

    task automatic compare_all();
        chk(dr_pin == m_pin, "R3 R4 R5 dr_pin", 32'(dr_pin), 32'(m_pin));
        chk(dr_oe == m_oe, "R2 dr_oe", 32'(dr_oe), 32'(m_oe));
        chk(stat_flags == m_stat, "R12 stat_flags", 32'(stat_flags), 32'(m_stat));
        chk(rd_data0 == m_rd[0], "R10 R11 rd_data0", 32'(rd_data0), 32'(m_rd[0]));
        chk(rd_data1 == m_rd[1], "R10 R11 rd_data1", 32'(rd_data1), 32'(m_rd[1]));
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        smp_valid = 2'b00; period_tick = 1'b0; rd_start = 1'b0; stat_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7021));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(dr_pin == 1'b1, "R1 pin", 32'(dr_pin), 1);
        chk(dr_oe == 1'b0, "R1 oe", 32'(dr_oe), 0);
        chk(stat_flags == 2'b11, "R1 stat", 32'(stat_flags), 3);
        chk(rd_data0 == '0 && rd_data1 == '0, "R1 rd", 32'(rd_data0 | rd_data1), 0);

        // R2 idle driven
        cfg_idle_drive = 1'b1; cyc();
        chk(dr_oe == 1'b1 && dr_pin == 1'b1, "R2 idle drive", {30'd0, dr_oe, dr_pin}, 3);
        cfg_idle_drive = 1'b0; cyc();
        chk(dr_oe == 1'b0, "R2 idle released", 32'(dr_oe), 0);

        // R3 R9 pulse from start, no settle
        cfg_mode = 2'b01; smp_valid = 2'b01; cyc();
        chk(dr_pin == 1'b0 && dr_oe == 1'b1, "R3 R9 pulse", {30'd0, dr_oe, dr_pin}, 2);
        cyc();
        chk(dr_pin == 1'b1, "R3 one cycle", 32'(dr_pin), 1);

        // R4 routing
        smp_valid = 2'b10; cyc();
        chk(dr_pin == 1'b1, "R4 mode01 ignores ch1", 32'(dr_pin), 1);
        cfg_mode = 2'b10; smp_valid = 2'b10; cyc();
        chk(dr_pin == 1'b0, "R4 mode10 ch1", 32'(dr_pin), 0);
        cyc();
        cfg_mode = 2'b11; smp_valid = 2'b10; cyc();
        chk(dr_pin == 1'b0, "R4 mode11 ch1", 32'(dr_pin), 0);
        cyc();

        // R5 linked follows lagging
        cfg_mode = 2'b00; lag_sel = 1'b1; smp_valid = 2'b01; cyc();
        chk(dr_pin == 1'b1, "R5 leading ignored", 32'(dr_pin), 1);
        smp_valid = 2'b10; cyc();
        chk(dr_pin == 1'b0, "R5 lagging pulses", 32'(dr_pin), 0);
        cyc();

        // R6 linked with a channel off
        chan_off = 2'b01; smp_valid = 2'b10; cyc();
        chk(dr_pin == 1'b1, "R6 linked off", 32'(dr_pin), 1);

        // R7 independent with a channel off
        cfg_mode = 2'b11; chan_off = 2'b10; smp_valid = 2'b10; cyc();
        chk(dr_pin == 1'b1, "R7 off channel silent", 32'(dr_pin), 1);
        smp_valid = 2'b01; cyc();
        chk(dr_pin == 1'b0, "R7 other channel", 32'(dr_pin), 0);
        chan_off = 2'b00; cyc();

        // R10 R11 linked snapshot and read
        stat_rd = 1'b1; cyc();
        chk(stat_flags == 2'b11, "R12 read sets", 32'(stat_flags), 3);
        cfg_mode = 2'b00; lag_sel = 1'b0;
        chan_data0 = 24'h111111; chan_data1 = 24'h222222; smp_valid = 2'b01; cyc();
        chk(stat_flags == 2'b00, "R12 linked clears both", 32'(stat_flags), 0);
        rd_start = 1'b1; cyc();
        chk(rd_data0 == 24'h111111, "R10 linked rd0", 32'(rd_data0), 32'h111111);
        chk(rd_data1 == 24'h222222, "R10 linked rd1", 32'(rd_data1), 32'h222222);
        cfg_mode = 2'b01; chan_data1 = 24'h333333; chan_data0 = 24'h444444; smp_valid = 2'b10; cyc();
        rd_start = 1'b1; cyc();
        chk(rd_data0 == 24'h111111 && rd_data1 == 24'h333333, "R10 own-event snapshot",
            32'(rd_data1), 32'h333333);
        chan_data0 = 24'h555555; smp_valid = 2'b01; cyc();
        chk(rd_data0 == 24'h111111, "R11 hold without read", 32'(rd_data0), 32'h111111);

        // R12 clear wins over read
        stat_rd = 1'b1; smp_valid = 2'b01; cyc();
        chk(stat_flags == 2'b10, "R12 clear wins", 32'(stat_flags), 2);

        // R8 settling hold
        cfg_settle_en = 1'b1; chan_off = 2'b11; cyc();
        chan_off = 2'b00;
        period_tick = 1'b1; cyc();
        period_tick = 1'b1; cyc();
        smp_valid = 2'b01; cyc();
        chk(dr_pin == 1'b1, "R8 held after two ticks", 32'(dr_pin), 1);
        smp_valid = 2'b01; period_tick = 1'b1; cyc();
        chk(dr_pin == 1'b1, "R8 held on third tick", 32'(dr_pin), 1);
        smp_valid = 2'b01; cyc();
        chk(dr_pin == 1'b0, "R8 released", 32'(dr_pin), 0);
        cyc();

        // random phase
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 31) == 0) cfg_settle_en = $urandom_range(0, 1) == 1;
            if ($urandom_range(0, 15) == 0) cfg_idle_drive = $urandom_range(0, 1) == 1;
            if ($urandom_range(0, 15) == 0) cfg_mode = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 15) == 0) lag_sel = $urandom_range(0, 1) == 1;
            for (int i = 0; i < 2; i++) begin
                if ($urandom_range(0, 19) == 0) chan_off[i] = ~chan_off[i];
                smp_valid[i] = $urandom_range(0, 2) == 0;
            end
            period_tick = $urandom_range(0, 3) == 0;
            rd_start = $urandom_range(0, 7) == 0;
            stat_rd = $urandom_range(0, 7) == 0;
            chan_data0 = DW'($urandom);
            chan_data1 = DW'($urandom);
            cyc();
        end
        finish_run();
    end

endmodule